// File: doc/BRIEF.md
# CCD Row Zero-Bias Preprocessor

This block sits between an image-sensor readout stream and whatever consumes a corrected frame. It accepts signed 8-bit samples through a valid/ready handshake and builds a 64 by 64 frame. Every sensor row arrives as 64 picture samples and then two dark-reference samples. The block first holds the 64 picture samples of a row in a row buffer. It then averages the two dark samples into a row bias and writes each buffered sample, less that bias, into the frame store. Only after that does it take the next row.

Once the last row has been written, the frame-done flag goes high and the corrected frame can be read. The current pixel is always shown on the output port, and a pop strobe moves to the next one in row-major order. Once the final pixel has been popped, the block reports no valid pixel until a new capture is started. A pop made while no pixel is valid changes nothing and raises a one-cycle error flag.

The controller has six states. IDLE follows reset. IMAGE takes picture samples. REF takes the two dark samples. APPLY writes the corrected row. SERVE hands out pixels. DRAINED is reached once the whole frame has been read. The transitions are as follows:
- capture_start goes from any state to IMAGE.
- IMAGE goes to REF after the 64th picture sample.
- REF goes to APPLY after the second dark sample.
- APPLY goes back to IMAGE after 64 writes. After the last row it goes to SERVE instead.
- SERVE goes to DRAINED on the pop of the final pixel.

Top module: `ccd_zero_bias`

## Requirements
- R1: While rst_n is low, and at the first edge after it rises, in_ready, pixel_valid, frame_done and pop_err are all 0 and pixel_o is 0.
- R2: A capture_start pulse begins a new frame from any state. From the next cycle in_ready is 1 and frame_done is 0, and the first accepted sample is row 0, column 0.
- R3: Each row consumes exactly 66 accepted samples: columns 0 to 63 first, then two dark samples. in_ready stays 1 until the 66th sample, then stays 0 for the 64 cycles of row correction.
- R4: The row bias is the sum of the two dark samples, formed as a 9-bit signed value and divided by two with truncation toward zero. For example, -3 and -4 give -3, and 127 and -128 give 0.
- R5: Each stored pixel is the picture sample minus its row's bias, taken modulo 256 with no saturation.
- R6: frame_done rises when the last row has been corrected. It stays 1 until the next capture_start. At that point pixel_valid is 1 and pixel_o shows row 0, column 0.
- R7: While pixel_valid is 1, pixel_o holds its value until a pop. Each pop moves to the next column, and from column 63 it wraps to column 0 of the next row.
- R8: After row 63, column 63 is popped, pixel_valid is 0 and pixel_o is 0 until the next capture_start.
- R9: A pop while pixel_valid is 0 has no effect on the frame or on the read position. pop_err is then 1 in exactly the following cycle.
- R10: A capture_start in the middle of a capture or a readout discards the partial frame. The next sample accepted is taken as row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| capture_start | input | 1 | One-cycle pulse that starts a new frame |
| in_valid | input | 1 | Sensor sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | 8 | Signed sensor sample |
| pop | input | 1 | Advance to the next corrected pixel |
| pixel_o | output | 8 | Current corrected pixel, 0 when not valid |
| pixel_valid | output | 1 | pixel_o holds a frame pixel |
| frame_done | output | 1 | Every row of the current frame is corrected |
| pop_err | output | 1 | One-cycle flag for a pop made with no valid pixel |

## Verification
A wrong column or row count shows up as a frame_done that comes too early or too late. It also shows as an in_ready gap that lands on the wrong sample, so row 0 already exposes it. A wrong bias or a misrouted row-buffer entry appears only when the frame is read out, as a wrong pixel at that exact row and column. For that reason every pixel of every frame is compared. A read pointer that slips shows as a shifted value or as pixel_valid falling before the 4096th pop. Dark-sample pairs that hit the limits of the signed range and odd negative sums are included to expose rounding and wrap faults.

// File: rtl/ccdzb_pkg.sv
package ccdzb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IMAGE,
        ST_REF,
        ST_APPLY,
        ST_SERVE,
        ST_DRAINED
    } ccdzb_state_e;

endpackage

// File: rtl/ccdzb_bias_calc.sv
// Mean of two signed dark samples, truncated toward zero.
module ccdzb_bias_calc #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] ref_a,
    input  logic [PW-1:0] ref_b,
    output logic [PW-1:0] bias
);

    logic signed [PW:0] sum;
    logic signed [PW:0] half;

    always_comb begin
        sum  = $signed({ref_a[PW-1], ref_a}) + $signed({ref_b[PW-1], ref_b});
        half = sum >>> 1;
        // arithmetic shift floors; a negative odd sum needs one added back
        if (sum[PW] && sum[0]) begin
            half = half + $signed({{PW{1'b0}}, 1'b1});
        end
        bias = half[PW-1:0];
    end

endmodule

// File: rtl/ccdzb_row_buffer.sv
// Holds one row of raw picture samples until its bias is known.
module ccdzb_row_buffer #(
    parameter int COLS = 64,
    parameter int PW   = 8,
    localparam int CW  = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [CW-1:0] idx,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata
);

    logic [PW-1:0] cells [COLS];

    for (genvar i = 0; i < COLS; i++) begin : g_cell
        logic [PW-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (we && (idx == CW'(i))) begin
                cell_q <= wdata;
            end
        end
        assign cells[i] = cell_q;
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/ccdzb_frame_store.sv
// Corrected frame: one write port, combinational read port.
module ccdzb_frame_store #(
    parameter int DEPTH = 4096,
    parameter int PW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [PW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [PW-1:0] rdata
);

    logic [PW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ccdzb_ctrl.sv
// Capture / correct / serve sequencer with the shared row and column counters.
module ccdzb_ctrl
    import ccdzb_pkg::*;
#(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_start,
    input  logic          in_valid,
    input  logic          pop,
    output logic          in_ready,
    output logic          row_we,
    output logic          ref_a_we,
    output logic          bias_we,
    output logic          mem_we,
    output logic          pixel_valid,
    output logic          frame_done,
    output logic          pop_err,
    output logic [RW-1:0] row_idx,
    output logic [CW-1:0] col_idx
);

    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

    ccdzb_state_e st_q, st_d;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic          ref_q;
    logic          accept;
    logic          col_end;
    logic          row_end;

    assign accept  = in_valid && in_ready;
    assign col_end = (col_q == COL_LAST);
    assign row_end = (row_q == ROW_LAST);

    // next state
    always_comb begin
        st_d = st_q;
        if (capture_start) begin
            st_d = ST_IMAGE;
        end else begin
            unique case (st_q)
                ST_IDLE:    st_d = ST_IDLE;
                ST_IMAGE:   if (accept && col_end) st_d = ST_REF;
                ST_REF:     if (accept && ref_q) st_d = ST_APPLY;
                ST_APPLY:   if (col_end) st_d = row_end ? ST_SERVE : ST_IMAGE;
                ST_SERVE:   if (pop && col_end && row_end) st_d = ST_DRAINED;
                ST_DRAINED: st_d = ST_DRAINED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        in_ready    = 1'b0;
        mem_we      = 1'b0;
        pixel_valid = 1'b0;
        unique case (st_q)
            ST_IDLE:    ;
            ST_IMAGE:   in_ready = 1'b1;
            ST_REF:     in_ready = 1'b1;
            ST_APPLY:   mem_we = 1'b1;
            ST_SERVE:   pixel_valid = 1'b1;
            ST_DRAINED: ;
        endcase
        row_we   = (st_q == ST_IMAGE) && accept;
        ref_a_we = (st_q == ST_REF) && accept && !ref_q;
        bias_we  = (st_q == ST_REF) && accept && ref_q;
    end

    // counters, done and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q      <= '0;
            col_q      <= '0;
            ref_q      <= 1'b0;
            frame_done <= 1'b0;
            pop_err    <= 1'b0;
        end else begin
            pop_err <= pop && !pixel_valid;
            if (capture_start) begin
                row_q      <= '0;
                col_q      <= '0;
                ref_q      <= 1'b0;
                frame_done <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IMAGE: begin
                        if (accept) begin
                            col_q <= col_end ? '0 : col_q + 1'b1;
                            ref_q <= 1'b0;
                        end
                    end
                    ST_REF: begin
                        if (accept) begin
                            ref_q <= !ref_q;
                        end
                    end
                    ST_APPLY: begin
                        col_q <= col_end ? '0 : col_q + 1'b1;
                        if (col_end) begin
                            if (row_end) begin
                                row_q      <= '0;
                                frame_done <= 1'b1;
                            end else begin
                                row_q <= row_q + 1'b1;
                            end
                        end
                    end
                    ST_SERVE: begin
                        if (pop) begin
                            col_q <= col_end ? '0 : col_q + 1'b1;
                            if (col_end) begin
                                row_q <= row_end ? '0 : row_q + 1'b1;
                            end
                        end
                    end
                    ST_IDLE, ST_DRAINED: ;
                endcase
            end
        end
    end

    assign row_idx = row_q;
    assign col_idx = col_q;

endmodule

// File: rtl/ccd_zero_bias.sv
module ccd_zero_bias
    import ccdzb_pkg::*;
#(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    parameter int PW   = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS),
    localparam int AW  = $clog2(ROWS * COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_start,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [PW-1:0] in_data,
    input  logic          pop,
    output logic [PW-1:0] pixel_o,
    output logic          pixel_valid,
    output logic          frame_done,
    output logic          pop_err
);

    logic          row_we;
    logic          ref_a_we;
    logic          bias_we;
    logic          mem_we;
    logic [RW-1:0] row_idx;
    logic [CW-1:0] col_idx;
    logic [PW-1:0] ref_a_q;
    logic [PW-1:0] bias_q;
    logic [PW-1:0] bias_new;
    logic [PW-1:0] raw_pix;
    logic [PW-1:0] fixed_pix;
    logic [PW-1:0] store_rd;
    logic [AW-1:0] addr;

    ccdzb_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture_start (capture_start),
        .in_valid      (in_valid),
        .pop           (pop),
        .in_ready      (in_ready),
        .row_we        (row_we),
        .ref_a_we      (ref_a_we),
        .bias_we       (bias_we),
        .mem_we        (mem_we),
        .pixel_valid   (pixel_valid),
        .frame_done    (frame_done),
        .pop_err       (pop_err),
        .row_idx       (row_idx),
        .col_idx       (col_idx)
    );

    ccdzb_bias_calc #(.PW(PW)) u_bias (
        .ref_a (ref_a_q),
        .ref_b (in_data),
        .bias  (bias_new)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_a_q <= '0;
            bias_q  <= '0;
        end else begin
            if (ref_a_we) ref_a_q <= in_data;
            if (bias_we)  bias_q  <= bias_new;
        end
    end

    ccdzb_row_buffer #(.COLS(COLS), .PW(PW)) u_row (
        .clk   (clk),
        .we    (row_we),
        .idx   (col_idx),
        .wdata (in_data),
        .rdata (raw_pix)
    );

    // wraparound subtraction, no saturation
    assign fixed_pix = raw_pix - bias_q;
    assign addr      = AW'(row_idx) * AW'(COLS) + AW'(col_idx);

    ccdzb_frame_store #(.DEPTH(ROWS * COLS), .PW(PW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr),
        .wdata (fixed_pix),
        .raddr (addr),
        .rdata (store_rd)
    );

    assign pixel_o = pixel_valid ? store_rd : '0;

endmodule

// File: rtl/ccd_zero_bias_chk.sv
module ccd_zero_bias_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          capture_start,
    input logic          pop,
    input logic          in_ready,
    input logic          pixel_valid,
    input logic          frame_done,
    input logic          pop_err,
    input logic [PW-1:0] pixel_o
);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!in_ready && !pixel_valid && !frame_done && !pop_err && pixel_o == '0));

    a_r2_start_opens_input: assert property (@(posedge clk) disable iff (!rst_n)
        capture_start |=> (in_ready && !frame_done));

    a_r3_no_input_while_serving: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && pixel_valid));

    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !capture_start) |=> frame_done);

    a_r7_pixel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel_valid && !pop && !capture_start) |=> (pixel_valid && $stable(pixel_o)));

    a_r8_drained_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !pixel_valid && !capture_start) |=> (!pixel_valid && pixel_o == '0));

    a_r9_bad_pop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !pixel_valid) |=> pop_err);

    a_r9_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pop_err |-> $past(pop && !pixel_valid));

endmodule

bind ccd_zero_bias ccd_zero_bias_chk #(.PW(PW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .capture_start (capture_start),
    .pop           (pop),
    .in_ready      (in_ready),
    .pixel_valid   (pixel_valid),
    .frame_done    (frame_done),
    .pop_err       (pop_err),
    .pixel_o       (pixel_o)
);

// File: tb/tb_ccd_zero_bias.sv
`timescale 1ns/1ps
module tb_ccd_zero_bias;

    localparam int ROWS = 64;
    localparam int COLS = 64;
    localparam int NV   = 10;
    // {dark0, dark1, expected bias} per R4
    localparam logic [23:0] REF_TAB [NV] = '{
        24'h0A140F, 24'h030403, 24'hFDFCFD, 24'h808080, 24'h7F7F7F,
        24'hFF0000, 24'h7F8000, 24'hFB02FF, 24'h646564, 24'h9C9B9C
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_start = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       pop = 1'b0;
    logic [7:0] pixel_o;
    logic       pixel_valid;
    logic       frame_done;
    logic       pop_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    always #5 clk = ~clk;

    ccd_zero_bias dut (
        .clk(clk), .rst_n(rst_n), .capture_start(capture_start),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .pop(pop), .pixel_o(pixel_o), .pixel_valid(pixel_valid),
        .frame_done(frame_done), .pop_err(pop_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] raw_pix(int seed, int r, int c);
        return 8'(r * 7 + c * 13 + seed * 29);
    endfunction

    function automatic logic [23:0] row_ref(int seed, int r);
        return REF_TAB[(r + seed) % NV];
    endfunction

    function automatic logic [7:0] exp_pix(int seed, int r, int c);
        logic [23:0] t;
        t = row_ref(seed, r);
        return 8'(raw_pix(seed, r, c) - t[7:0]);
    endfunction

    task automatic push(input logic [7:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic start_pulse();
        @(negedge clk);
        capture_start = 1'b1;
        @(posedge clk);
        #1 capture_start = 1'b0;
    endtask

    task automatic bad_pop(input string req);
        @(negedge clk);
        pop = 1'b1;
        @(posedge clk);
        #1 pop = 1'b0;
        @(negedge clk);
        check({req, " pop_err raised"}, int'(pop_err), 1);
        check({req, " pixel_valid low"}, int'(pixel_valid), 0);
        @(negedge clk);
        check({req, " pop_err one cycle"}, int'(pop_err), 0);
    endtask

    task automatic send_frame(input int seed);
        for (int r = 0; r < ROWS; r++) begin
            logic [23:0] t;
            t = row_ref(seed, r);
            for (int c = 0; c < COLS; c++) push(raw_pix(seed, r, c));
            if (r == 0) begin
                @(negedge clk);
                check("R3 ready before dark samples", int'(in_ready), 1);
            end
            push(t[23:16]);
            push(t[15:8]);
            if (r == 0) begin
                @(negedge clk);
                check("R3 ready drops after 66 samples", int'(in_ready), 0);
            end
        end
        while (!frame_done) @(negedge clk);
        @(negedge clk);
        check("R6 frame_done", int'(frame_done), 1);
        check("R6 pixel_valid", int'(pixel_valid), 1);
    endtask

    // reads npix pixels (all when npix == ROWS*COLS), checking each
    task automatic read_frame(input int seed, input int npix);
        int k = 0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (k < npix) begin
                    @(negedge clk);
                    pop = 1'b0;
                    check("R7 valid during readout", int'(pixel_valid), 1);
                    check("R4 R5 R7 corrected pixel", int'(pixel_o), int'(exp_pix(seed, r, c)));
                    pop = 1'b1;
                    k++;
                end
            end
        end
        @(negedge clk);
        pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 during reset
        repeat (3) @(negedge clk);
        check("R1 in_ready", int'(in_ready), 0);
        check("R1 pixel_valid", int'(pixel_valid), 0);
        check("R1 frame_done", int'(frame_done), 0);
        check("R1 pop_err", int'(pop_err), 0);
        check("R1 pixel_o", int'(pixel_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(in_ready), 0);

        bad_pop("R9 pop in idle");

        // R2 start, R10 partial row discarded
        start_pulse();
        @(negedge clk);
        check("R2 in_ready after start", int'(in_ready), 1);
        check("R2 frame_done low", int'(frame_done), 0);
        bad_pop("R9 pop during capture");
        for (int i = 0; i < 30; i++) push(8'hA5);
        start_pulse();
        send_frame(1);

        // R7 hold without pop
        repeat (3) @(negedge clk);
        check("R7 holds first pixel", int'(pixel_o), int'(exp_pix(1, 0, 0)));
        read_frame(1, ROWS * COLS);
        check("R8 valid low after last pop", int'(pixel_valid), 0);
        check("R8 pixel_o zero", int'(pixel_o), 0);
        check("R6 done held after drain", int'(frame_done), 1);
        bad_pop("R9 pop when drained");

        // second frame from drained state
        start_pulse();
        @(negedge clk);
        check("R6 done cleared by start", int'(frame_done), 0);
        send_frame(5);
        read_frame(5, 100);

        // R10 restart during readout
        start_pulse();
        @(negedge clk);
        check("R10 readout aborted", int'(pixel_valid), 0);
        send_frame(8);
        read_frame(8, ROWS * COLS);
        check("R8 valid low after frame 3", int'(pixel_valid), 0);

        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule